// File: doc/BRIEF.md
# Retired-Instruction Periodic Interrupt Timer

This block raises a periodic interrupt request for a processor core. It counts retired instructions instead of clock cycles, so the interrupt rate follows program progress and does not depend on stalls. Two dividers are chained. A first-stage prescaler divides the retire pulses by a programmable divisor. A second-stage timer divides the prescaler ticks by a programmable count. An interrupt becomes pending once every divisor × count retired instructions. Both constants start at 1000, which gives one interrupt per million retired instructions.

The core writes both constants, the mask bit and the clear strobe through dedicated write ports. The core's trap handling drives these ports: trap code 10 writes the timer count, 11 writes the prescale divisor, 12 writes the mask and 13 clears the interrupt. The block presents a request together with a fixed vector word address of 1000 and the index of the link register (31). When the core takes the request, the block pulses a link-write strobe so that the core saves its return address in register 31. The block then holds the interrupt as in service until software clears it.

Top module: `instr_period_irq`

## Requirements
- R1: After reset both constants equal 1000, `irq_o` is 0 and the state is idle. With only the count rewritten to 1, the 1000th retire raises the request and the 999th does not. With only the divisor rewritten to 1, the same holds.
- R2: The prescaler ticks on every divisor-th retire. The timer wraps on every count-th tick. The request becomes pending, and `irq_o` rises, on the clock edge that ends the cycle in which the completing retire was presented. Idle cycles between retires do not advance either stage.
- R3: A write to either constant restarts that stage from zero. A retire presented in the same cycle as a divisor write is not counted.
- R4: A constant written as 0 behaves exactly like 1.
- R5: `mask_i`=1 written with `mask_we_i` disables `irq_o` from the next cycle. Writing 0 enables it again. A pending interrupt is kept while masked, and the counters keep running.
- R6: When `irq_o`=1 and `take_i`=1, `link_we_o` is 1 in that same cycle. The state then moves to in service and `irq_o` falls. While in service, completed periods raise no new request. A pending request that meets `take_i` absorbs a period completing in the same cycle.
- R7: `clr_i` returns the block to idle from pending or in service. If a period completes in the same cycle as `clr_i`, the clear wins and nothing is pending afterwards.
- R8: `vec_o` always reads 1000 and `link_idx_o` always reads 31.
- R9: Retires that complete no full period never raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| div_we_i | input | 1 | Load prescale divisor from `wdata_i` |
| cnt_we_i | input | 1 | Load timer count from `wdata_i` |
| wdata_i | input | 32 | Constant value for either write port |
| mask_we_i | input | 1 | Load mask bit from `mask_i` |
| mask_i | input | 1 | 1 disables the request, 0 enables it |
| clr_i | input | 1 | Clear pending or in-service interrupt |
| take_i | input | 1 | Core accepts the request this cycle |
| irq_o | output | 1 | Interrupt request (pending and unmasked) |
| vec_o | output | 32 | Vector word address |
| link_we_o | output | 1 | Core must save its return address now |
| link_idx_o | output | 5 | Register that receives the return address |

## Verification
Assertions check, every cycle, that each stage's count stays below its effective limit and that a constant write restarts its stage. They also check that a clear always leaves the block idle and that in service persists until cleared. Two further rules are checked the same way: a mask-disable silences the request on the next cycle, and a link write always ends the request. Only the bench scenarios can show that the period equals the product of the two constants. The same holds for the reset defaults of 1000, the zero-as-one rule, a pending interrupt surviving a mask, and the same-cycle priorities between retire and write and between clear and completion.

// File: rtl/instr_period_irq_pkg.sv
package instr_period_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_SERV = 2'd2
    } irq_st_e;

    typedef struct packed {
        irq_st_e st;
        logic    mask;
    } irq_reg_t;
endpackage

// File: rtl/ipi_div_stage.sv
module ipi_div_stage #(
    parameter int W         = 32,
    parameter int RST_LIMIT = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         load_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);
    typedef struct packed {
        logic [W-1:0] limit;
        logic [W-1:0] count;
    } stage_t;

    stage_t       r_q, r_d;
    logic [W-1:0] eff_limit;
    logic         at_end;

    always_comb begin
        eff_limit = (r_q.limit == '0) ? W'(1) : r_q.limit;
        at_end    = (r_q.count >= eff_limit - W'(1));
        tick_o    = step_i && !load_i && at_end;
        r_d       = r_q;
        if (load_i) begin
            r_d.limit = limit_i;
            r_d.count = '0;
        end else if (step_i) begin
            r_d.count = at_end ? '0 : r_q.count + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.limit <= W'(RST_LIMIT);
            r_q.count <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.count < eff_limit);

    p_load_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (r_q.count == '0));
endmodule

// File: rtl/ipi_irq_state.sv
module ipi_irq_state
    import instr_period_irq_pkg::*;
#(
    parameter logic RST_MASK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic mask_we_i,
    input  logic mask_i,
    input  logic clr_i,
    input  logic take_i,
    output logic irq_o
);
    irq_reg_t r_q, r_d;

    always_comb begin
        irq_o = (r_q.st == ST_PEND) && !r_q.mask;
        r_d   = r_q;
        if (mask_we_i) r_d.mask = mask_i;
        if (clr_i) begin
            r_d.st = ST_IDLE;
        end else if (r_q.st == ST_SERV) begin
            r_d.st = ST_SERV;
        end else if (irq_o && take_i) begin
            r_d.st = ST_SERV;
        end else if (fire_i) begin
            r_d.st = ST_PEND;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.mask <= RST_MASK;
        end else begin
            r_q <= r_d;
        end
    end

    p_clear_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (r_q.st == ST_IDLE));

    p_service_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SERV && !clr_i) |=> (r_q.st == ST_SERV));

    p_take_enters_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && take_i && !clr_i) |=> (r_q.st == ST_SERV));

    p_mask_silences_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we_i && mask_i) |=> !irq_o);
endmodule

// File: rtl/instr_period_irq.sv
module instr_period_irq #(
    parameter int CNT_W    = 32,
    parameter int RST_DIV  = 1000,
    parameter int RST_CNT  = 1000,
    parameter int VEC_W    = 32,
    parameter int VEC_ADDR = 1000,
    parameter int IDX_W    = 5,
    parameter int LINK_REG = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             div_we_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             mask_we_i,
    input  logic             mask_i,
    input  logic             clr_i,
    input  logic             take_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             link_we_o,
    output logic [IDX_W-1:0] link_idx_o
);
    logic pre_tick;
    logic period_done;

    ipi_div_stage #(.W(CNT_W), .RST_LIMIT(RST_DIV)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (retire_i),
        .load_i  (div_we_i),
        .limit_i (wdata_i),
        .tick_o  (pre_tick)
    );

    ipi_div_stage #(.W(CNT_W), .RST_LIMIT(RST_CNT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (pre_tick),
        .load_i  (cnt_we_i),
        .limit_i (wdata_i),
        .tick_o  (period_done)
    );

    ipi_irq_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (period_done),
        .mask_we_i (mask_we_i),
        .mask_i    (mask_i),
        .clr_i     (clr_i),
        .take_i    (take_i),
        .irq_o     (irq_o)
    );

    always_comb begin
        vec_o      = VEC_W'(VEC_ADDR);
        link_idx_o = IDX_W'(LINK_REG);
        link_we_o  = irq_o && take_i;
    end

    p_link_ends_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |=> !irq_o);

    p_idle_retire_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !irq_o && !mask_we_i) |=> !irq_o);
endmodule

// File: tb/instr_period_irq_bench.sv
module instr_period_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        retire, div_we, cnt_we, mask_we, mask_in, clr, take;
    logic [31:0] wdata;
    logic        irq_o, link_we_o;
    logic [31:0] vec_o;
    logic [4:0]  link_idx_o;

    int checks = 0;
    int failures = 0;

    int unsigned m_pdiv, m_tcnt, m_pc, m_tc;
    int          m_st;
    logic        m_mask;

    always #10 clk = ~clk;

    instr_period_irq u_instr_period_irq (
        .clk(clk), .rst_n(rst_n), .retire_i(retire), .div_we_i(div_we),
        .cnt_we_i(cnt_we), .wdata_i(wdata), .mask_we_i(mask_we), .mask_i(mask_in),
        .clr_i(clr), .take_i(take), .irq_o(irq_o), .vec_o(vec_o),
        .link_we_o(link_we_o), .link_idx_o(link_idx_o)
    );

    function automatic int unsigned eff(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic model_irq();
        return (m_st == 1) && !m_mask;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic model_step(input logic r, dw, cw, input logic [31:0] wd,
                              input logic mw, mv, c, t);
        logic ptick, fire, irq_now;
        ptick = 1'b0;
        fire = 1'b0;
        irq_now = model_irq();
        if (dw) begin
            m_pdiv = wd; m_pc = 0;
        end else if (r) begin
            if (m_pc + 1 >= eff(m_pdiv)) begin m_pc = 0; ptick = 1'b1; end
            else m_pc++;
        end
        if (cw) begin
            m_tcnt = wd; m_tc = 0;
        end else if (ptick) begin
            if (m_tc + 1 >= eff(m_tcnt)) begin m_tc = 0; fire = 1'b1; end
            else m_tc++;
        end
        if (c) m_st = 0;
        else if (m_st == 2) m_st = 2;
        else if (irq_now && t) m_st = 2;
        else if (fire) m_st = 1;
        if (mw) m_mask = mv;
    endtask

    task automatic step(input logic r, dw, cw, input logic [31:0] wd,
                        input logic mw, mv, c, t, input string tag);
        retire = r; div_we = dw; cnt_we = cw; wdata = wd;
        mask_we = mw; mask_in = mv; clr = c; take = t;
        #1;
        check({tag, " link_we"}, 32'(link_we_o), 32'(t && model_irq()));
        model_step(r, dw, cw, wd, mw, mv, c, t);
        @(posedge clk);
        @(negedge clk);
        check({tag, " irq"}, 32'(irq_o), 32'(model_irq()));
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic retires(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        retire = 0; div_we = 0; cnt_we = 0; wdata = 0;
        mask_we = 0; mask_in = 0; clr = 0; take = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_pdiv = 1000; m_tcnt = 1000; m_pc = 0; m_tc = 0; m_st = 0; m_mask = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R8 and R1 reset values
        check("R8 vec", vec_o, 32'd1000);
        check("R8 link_idx", 32'(link_idx_o), 32'd31);
        check("R1 irq after reset", 32'(irq_o), 32'd0);

        // R1 default divisor 1000
        step(0, 0, 1, 32'd1, 0, 0, 0, 0, "R1 cnt write");
        retires(999, "R1 div default");
        check("R1 999 retires", 32'(irq_o), 32'd0);
        retires(1, "R1 div default");
        check("R1 1000th retire", 32'(irq_o), 32'd1);

        // R6 take, link strobe, no new request while in service
        step(0, 1, 0, 32'd1, 0, 0, 0, 0, "R6 div write");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R6 take");
        check("R6 irq after take", 32'(irq_o), 32'd0);
        retires(3, "R6 in service");
        check("R6 no new request", 32'(irq_o), 32'd0);

        // R7 clear from service then re-arm
        step(0, 0, 0, 0, 0, 0, 1, 0, "R7 clear");
        check("R7 idle after clear", 32'(irq_o), 32'd0);
        retires(1, "R7 rearm");
        check("R7 rearmed", 32'(irq_o), 32'd1);

        // R5 mask keeps pending
        step(0, 0, 0, 0, 1, 1, 0, 0, "R5 mask on");
        check("R5 masked", 32'(irq_o), 32'd0);
        retires(4, "R5 counting masked");
        step(0, 0, 0, 0, 1, 0, 0, 0, "R5 mask off");
        check("R5 pending kept", 32'(irq_o), 32'd1);
        step(0, 0, 0, 0, 0, 0, 1, 0, "R7 clear pending");
        check("R7 pending cleared", 32'(irq_o), 32'd0);

        // R4 zero constants
        step(0, 1, 1, 32'd0, 0, 0, 0, 0, "R4 zero write");
        retires(1, "R4 zero as one");
        check("R4 single retire fires", 32'(irq_o), 32'd1);
        step(0, 0, 0, 0, 0, 0, 1, 0, "R4 clear");

        // R3 restart and dropped retire
        step(0, 0, 1, 32'd1, 0, 0, 0, 0, "R3 cnt");
        step(0, 1, 0, 32'd3, 0, 0, 0, 0, "R3 div");
        retires(2, "R3 partial");
        step(1, 1, 0, 32'd3, 0, 0, 0, 0, "R3 rewrite with retire");
        retires(2, "R3 after restart");
        check("R3 not yet", 32'(irq_o), 32'd0);
        retires(1, "R3 after restart");
        check("R3 fires on third", 32'(irq_o), 32'd1);
        step(0, 0, 0, 0, 0, 0, 1, 0, "R3 clear");

        // R7 clear beats completion
        step(0, 1, 0, 32'd1, 0, 0, 0, 0, "R7 div");
        step(1, 0, 0, 0, 0, 0, 1, 0, "R7 clear vs fire");
        check("R7 clear wins", 32'(irq_o), 32'd0);

        // R2 product period with gaps
        step(0, 1, 1, 32'd2, 0, 0, 0, 0, "R2 set 2x2");
        step(0, 0, 1, 32'd3, 0, 0, 0, 0, "R2 cnt 3");
        for (int i = 0; i < 5; i++) begin
            retires(1, "R2 period");
            idle("R2 gap");
        end
        check("R2 five retires", 32'(irq_o), 32'd0);
        retires(1, "R2 period");
        check("R2 sixth retire", 32'(irq_o), 32'd1);

        // R1 default count 1000
        do_reset();
        step(0, 1, 0, 32'd1, 0, 0, 0, 0, "R1 div write");
        retires(999, "R1 cnt default");
        check("R1 cnt 999", 32'(irq_o), 32'd0);
        retires(1, "R1 cnt default");
        check("R1 cnt 1000", 32'(irq_o), 32'd1);

        // R9 and all others: random mix
        do_reset();
        step(0, 1, 0, $urandom % 5, 0, 0, 0, 0, "R9 rand div");
        step(0, 0, 1, $urandom % 5, 0, 0, 0, 0, "R9 rand cnt");
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, ($urandom % 97) == 0, ($urandom % 89) == 0,
                 $urandom % 5, ($urandom % 53) == 0, 1'($urandom % 2),
                 ($urandom % 61) == 0, ($urandom % 3) == 0, "R9 random");
        end
        check("R8 vec end", vec_o, 32'd1000);
        report();
    end
endmodule